// File: doc/BRIEF.md
# Speculative Load Snoop Queue

This block tracks loads that an out-of-order core has executed early, ahead of older memory operations, so that sequentially consistent ordering can be kept while still reordering. Each early load is written into a small circular queue together with the cache-line part of its address. Loads leave the queue in program order once they retire. Every remote bus event that the core's cache observes is also shown to the queue, one event per cycle and in bus order. Remote writes and upgrades are compared against all live entries at once. Any hit marks that load as stale.

While any entry is marked, the queue offers a replay request that names the oldest marked entry. The core accepts the request with a valid/ready handshake. The queue then drops that entry and every younger one, and moves its tail back to the replayed slot. The core re-issues those loads in order, and the re-executed loads pick up the coherent values.

Back-pressure rules: allocation takes place only in a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` is low when the queue is full or while a replay is pending. Retirement takes place only when `retire_valid` and `retire_ready` are both high. `retire_ready` is low when the queue is empty or when the head entry is marked. A replay is consumed when `replay_valid` and `replay_ready` are both high. The snoop input has no ready: the bus cannot be stalled.

Top module: `spec_lq_snoop`

## Requirements
- R1: After reset the queue is empty. `lq_full` and `replay_valid` are 0, `alloc_ready` and `alloc_idx` read 1 and 0, and `retire_ready` is 0.
- R2: An accepted allocation stores the line address (`alloc_addr >> LINE_OFF`) in slot `alloc_idx`. `alloc_idx` then advances by one, modulo DEPTH, where DEPTH is a power of two.
- R3: `lq_full` is high when DEPTH entries are live. While it is high, `alloc_ready` is 0 and `alloc_valid` has no effect.
- R4: `retire_ready` is high when the queue is non-empty and its head entry is unmarked. An accepted retirement frees the head entry, so entries leave in program order.
- R5: A snoop with `snp_type` 1 (write) or 2 (upgrade) marks every live entry whose line address equals `snp_addr >> LINE_OFF`. The low LINE_OFF address bits take no part in the compare.
- R6: A snoop with `snp_type` 0 (read) or 3 (reserved) marks nothing.
- R7: `replay_valid` is high while any live entry is marked. `replay_idx` names the marked entry nearest the head. A pending request stays up until it is accepted.
- R8: An accepted replay removes the named entry and every younger entry. `alloc_idx` then equals the replayed index. `alloc_ready` is 0 while `replay_valid` is high.
- R9: A snoop in the same cycle as a retirement does not mark the retiring entry. A snoop in the same cycle as an allocation does not mark the entry being written.
- R10: A snoop takes effect on the following cycle. Consecutive snoops, one per cycle, are applied in the order they arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Early load wants a queue slot |
| alloc_addr | input | ADDR_W | Byte address of the early load |
| alloc_ready | output | 1 | Queue can accept an allocation |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation will take (tail) |
| lq_full | output | 1 | All slots are live |
| retire_valid | input | 1 | Core retires the oldest load |
| retire_ready | output | 1 | Head entry may retire |
| snp_valid | input | 1 | Remote bus event present this cycle |
| snp_type | input | 2 | 0 read, 1 write, 2 upgrade, 3 reserved |
| snp_addr | input | ADDR_W | Byte address of the bus event |
| replay_valid | output | 1 | A marked entry awaits replay |
| replay_idx | output | log2(DEPTH) | Oldest marked slot |
| replay_ready | input | 1 | Core accepts the replay and flushes |

## Verification
The bench builds the queue with DEPTH 4, ADDR_W 16 and LINE_OFF 4. At that size the queue fills, wraps and drains many times within a few thousand cycles. Random addresses are drawn from a pool of four lines, each with random offset bits. This makes several entries on the same line common, so single and multiple matches, offset-insensitive compares and oldest-match selection all come up often. Because the depth is small, snoops also coincide often with retirement, allocation and replay flushes.

// File: rtl/lq_snoop_pkg.sv
package lq_snoop_pkg;
  typedef enum logic [1:0] {
    SNP_READ    = 2'd0,
    SNP_WRITE   = 2'd1,
    SNP_UPGRADE = 2'd2,
    SNP_RSVD    = 2'd3
  } snp_kind_e;

  // Only remote writes and upgrades make an early load stale.
  function automatic logic snp_is_invalidating(input logic [1:0] kind);
    return (kind == SNP_WRITE) || (kind == SNP_UPGRADE);
  endfunction
endpackage

// File: rtl/lq_entry.sv
module lq_entry #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              clr,
  input  logic              chk_en,
  input  logic [LINE_W-1:0] chk_line,
  output logic              valid_o,
  output logic              mark_o
);
  logic              valid_q, mark_q;
  logic [LINE_W-1:0] line_q;
  logic              hit;

  assign hit = valid_q && chk_en && (line_q == chk_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mark_q  <= 1'b0;
      line_q  <= '0;
    end else if (clr) begin
      // retire or flush wins over a same-cycle snoop hit
      valid_q <= 1'b0;
      mark_q  <= 1'b0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      mark_q  <= 1'b0;
      line_q  <= wr_line;
    end else if (hit) begin
      mark_q  <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign mark_o  = mark_q;
endmodule

// File: rtl/lq_age_pick.sv
module lq_age_pick #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] mark_vec,
  input  logic [IDX_W-1:0] head,
  output logic             found,
  output logic [IDX_W-1:0] off,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] pos;

  // Scan from youngest to oldest age so the oldest marked slot is kept last.
  always_comb begin
    found = 1'b0;
    off   = '0;
    pos   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      pos = head + IDX_W'(k);
      if (mark_vec[pos]) begin
        found = 1'b1;
        off   = IDX_W'(k);
      end
    end
    idx = head + off;
  end
endmodule

// File: rtl/spec_lq_snoop.sv
module spec_lq_snoop
  import lq_snoop_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              lq_full,
  input  logic              retire_valid,
  output logic              retire_ready,
  input  logic              snp_valid,
  input  logic [1:0]        snp_type,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              replay_valid,
  output logic [IDX_W-1:0]  replay_idx,
  input  logic              replay_ready
);
  localparam int PTR_W  = IDX_W + 1;
  localparam int LINE_W = ADDR_W - LINE_OFF;

  logic [PTR_W-1:0]  head_q, tail_q, count;
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic [DEPTH-1:0]  valid_vec, mark_vec;
  logic              empty;
  logic              alloc_fire, retire_fire, rep_fire, chk_en;
  logic              rep_found;
  logic [IDX_W-1:0]  rep_off, rep_idx;
  logic [LINE_W-1:0] alloc_line, snp_line;
  logic              unused_offset_bits;

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign count    = tail_q - head_q;
  assign empty    = (count == '0);
  assign lq_full  = (count == PTR_W'(DEPTH));

  assign alloc_line = alloc_addr[ADDR_W-1:LINE_OFF];
  assign snp_line   = snp_addr[ADDR_W-1:LINE_OFF];
  assign unused_offset_bits = ^{alloc_addr[LINE_OFF-1:0], snp_addr[LINE_OFF-1:0]};

  assign chk_en = snp_valid && snp_is_invalidating(snp_type);

  assign alloc_ready  = !lq_full && !rep_found;
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign retire_ready = !empty && !mark_vec[head_idx];
  assign retire_fire  = retire_valid && retire_ready;
  assign rep_fire     = rep_found && replay_ready;

  lq_age_pick #(.DEPTH(DEPTH)) u_pick (
    .mark_vec (mark_vec),
    .head     (head_idx),
    .found    (rep_found),
    .off      (rep_off),
    .idx      (rep_idx)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [IDX_W-1:0] age;
    logic             in_flush, clr, wr;
    assign age      = IDX_W'(i) - head_idx;
    assign in_flush = rep_fire && (age >= rep_off) && ({1'b0, age} < count);
    assign clr      = (retire_fire && (head_idx == IDX_W'(i))) || in_flush;
    assign wr       = alloc_fire && (tail_idx == IDX_W'(i));

    lq_entry #(.LINE_W(LINE_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr),
      .wr_line  (alloc_line),
      .clr      (clr),
      .chk_en   (chk_en),
      .chk_line (snp_line),
      .valid_o  (valid_vec[i]),
      .mark_o   (mark_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (retire_fire) head_q <= head_q + 1'b1;
      if (rep_fire)        tail_q <= head_q + PTR_W'(rep_off);
      else if (alloc_fire) tail_q <= tail_q + 1'b1;
    end
  end

  logic unused_valid_vec;
  assign unused_valid_vec = ^valid_vec;

  assign alloc_idx    = tail_idx;
  assign replay_valid = rep_found;
  assign replay_idx   = rep_idx;
endmodule

// File: rtl/spec_lq_snoop_chk.sv
module spec_lq_snoop_chk #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             lq_full,
  input logic             retire_valid,
  input logic             retire_ready,
  input logic             snp_valid,
  input logic [1:0]       snp_type,
  input logic             replay_valid,
  input logic [IDX_W-1:0] replay_idx,
  input logic             replay_ready
);
  AST_ALLOC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_idx == IDX_W'($past(alloc_idx) + 1'b1))); // R2

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_full && !(retire_valid && retire_ready) && !(replay_valid && replay_ready)) |=> lq_full); // R3

  AST_NO_SPURIOUS_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!replay_valid && !(snp_valid && (snp_type == 2'd1 || snp_type == 2'd2))) |=> !replay_valid); // R6

  AST_REPLAY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_valid && !replay_ready) |=> replay_valid); // R7

  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_valid && replay_ready) |=> (alloc_idx == $past(replay_idx))); // R8
endmodule

bind spec_lq_snoop spec_lq_snoop_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .alloc_idx    (alloc_idx),
  .lq_full      (lq_full),
  .retire_valid (retire_valid),
  .retire_ready (retire_ready),
  .snp_valid    (snp_valid),
  .snp_type     (snp_type),
  .replay_valid (replay_valid),
  .replay_idx   (replay_idx),
  .replay_ready (replay_ready)
);

// File: tb/tb_spec_lq_snoop.sv
module tb_spec_lq_snoop;
  localparam int D   = 4;
  localparam int AW  = 16;
  localparam int OFF = 4;
  localparam int IW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, retire_valid = 1'b0, snp_valid = 1'b0, replay_ready = 1'b0;
  logic [AW-1:0] alloc_addr = '0, snp_addr = '0;
  logic [1:0] snp_type = 2'd0;
  logic alloc_ready, lq_full, retire_ready, replay_valid;
  logic [IW-1:0] alloc_idx, replay_idx;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_valid[D];
  int m_mark[D];
  int m_line[D];
  int head = 0;
  int cnt = 0;

  always #4 clk = ~clk;

  spec_lq_snoop #(.DEPTH(D), .ADDR_W(AW), .LINE_OFF(OFF)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_ready(alloc_ready),
    .alloc_idx(alloc_idx), .lq_full(lq_full),
    .retire_valid(retire_valid), .retire_ready(retire_ready),
    .snp_valid(snp_valid), .snp_type(snp_type), .snp_addr(snp_addr),
    .replay_valid(replay_valid), .replay_idx(replay_idx), .replay_ready(replay_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int any_mark();
    for (int k = 0; k < cnt; k++) if (m_mark[(head + k) % D] != 0) return 1;
    return 0;
  endfunction

  function automatic int oldest_off();
    for (int k = 0; k < cnt; k++) if (m_mark[(head + k) % D] != 0) return k;
    return 0;
  endfunction

  task automatic check_outputs();
    int rv;
    rv = any_mark();
    chk("R3 lq_full", int'(lq_full), (cnt == D) ? 1 : 0);
    chk("R2 alloc_idx", int'(alloc_idx), (head + cnt) % D);
    chk("R8 alloc_ready", int'(alloc_ready), (cnt < D && rv == 0) ? 1 : 0);
    chk("R4 retire_ready", int'(retire_ready), (cnt > 0 && m_mark[head] == 0) ? 1 : 0);
    chk("R7 replay_valid", int'(replay_valid), rv);
    if (rv != 0) chk("R7 replay_idx", int'(replay_idx), (head + oldest_off()) % D);
  endtask

  task automatic model_update(input bit av, input int aaddr, input bit rv, input bit sv,
                              input int st, input int saddr, input bit rpr);
    int pend, ro, af, rf, ff, tailpos, ncnt;
    pend = any_mark();
    ro = oldest_off();
    af = (av && cnt < D && pend == 0) ? 1 : 0;
    rf = (rv && cnt > 0 && m_mark[head] == 0) ? 1 : 0;
    ff = (pend != 0 && rpr) ? 1 : 0;
    tailpos = (head + cnt) % D;
    if (sv && (st == 1 || st == 2))
      for (int i = 0; i < D; i++)
        if (m_valid[i] != 0 && m_line[i] == ((saddr >> OFF) & 12'hfff)) m_mark[i] = 1;
    ncnt = cnt;
    if (ff != 0) begin
      for (int k = ro; k < cnt; k++) begin
        m_valid[(head + k) % D] = 0;
        m_mark[(head + k) % D] = 0;
      end
      ncnt = ro;
    end
    if (rf != 0) begin
      m_valid[head] = 0;
      m_mark[head] = 0;
      head = (head + 1) % D;
      ncnt--;
    end
    if (af != 0) begin
      m_valid[tailpos] = 1;
      m_mark[tailpos] = 0;
      m_line[tailpos] = (aaddr >> OFF) & 12'hfff;
      ncnt++;
    end
    cnt = ncnt;
  endtask

  task automatic step(input bit av, input int aaddr, input bit rv, input bit sv,
                      input int st, input int saddr, input bit rpr);
    check_outputs();
    alloc_valid = av; alloc_addr = aaddr[AW-1:0];
    retire_valid = rv;
    snp_valid = sv; snp_type = st[1:0]; snp_addr = saddr[AW-1:0];
    replay_ready = rpr;
    model_update(av, aaddr, rv, sv, st, saddr, rpr);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) begin m_valid[i] = 0; m_mark[i] = 0; m_line[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 lq_full", int'(lq_full), 0);
    chk("R1 replay_valid", int'(replay_valid), 0);
    chk("R1 alloc_ready", int'(alloc_ready), 1);
    chk("R1 alloc_idx", int'(alloc_idx), 0);
    chk("R1 retire_ready", int'(retire_ready), 0);

    // R2 R3: fill to full, then try one more
    step(1, 'h100, 0, 0, 0, 0, 0);
    step(1, 'h200, 0, 0, 0, 0, 0);
    step(1, 'h300, 0, 0, 0, 0, 0);
    step(1, 'h400, 0, 0, 0, 0, 0);
    step(1, 'h500, 0, 0, 0, 0, 0);
    chk("R3 full holds after ignored alloc", int'(lq_full), 1);

    // R6: read and reserved snoops to a live line
    step(0, 0, 0, 1, 0, 'h205, 0);
    step(0, 0, 0, 1, 3, 'h20a, 0);
    chk("R6 no replay after read/reserved", int'(replay_valid), 0);

    // R5 R10: write with different offset bits marks slot 1, seen next cycle
    step(0, 0, 0, 1, 1, 'h20f, 0);
    chk("R10 mark visible next cycle", int'(replay_valid), 1);
    chk("R5 write match idx", int'(replay_idx), 1);
    // R5 R7: upgrade hits slot 0, which is older
    step(0, 0, 0, 1, 2, 'h100, 0);
    chk("R7 oldest marked", int'(replay_idx), 0);
    // R8: accept replay, everything flushed
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R8 tail back to replayed slot", int'(alloc_idx), 0);
    chk("R8 queue empty", int'(retire_ready), 0);

    // R9: retire together with a matching write
    step(1, 'h600, 0, 0, 0, 0, 0);
    step(1, 'h700, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 1, 'h603, 0);
    chk("R9 retiring entry not marked", int'(replay_valid), 0);
    // R9: allocation together with a matching write
    step(1, 'h800, 0, 1, 1, 'h80c, 0);
    chk("R9 new entry not marked", int'(replay_valid), 0);
    // R10: two back-to-back snoops, both applied
    step(0, 0, 0, 1, 1, 'h800, 0);
    step(0, 0, 0, 1, 2, 'h700, 0);
    chk("R10 second snoop applied, oldest slot", int'(replay_idx), 1);
    step(0, 0, 0, 0, 0, 0, 1);
    idle();

    // Random traffic over a small line pool
    for (int n = 0; n < 4000; n++) begin
      int aa, sa, st;
      aa = (($urandom % 4) << OFF) | ($urandom % 16);
      sa = (($urandom % 4) << OFF) | ($urandom % 16);
      st = $urandom % 4;
      step(($urandom % 10) < 6, aa, ($urandom % 10) < 3, ($urandom % 2) == 1, st, sa,
           ($urandom % 10) < 4);
    end
    check_outputs();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule